// File: doc/BRIEF.md
# Virtual error syndrome register unit

This unit holds the syndrome that is reported when a virtual asynchronous error is delivered to the guest kernel level. It keeps two fields inside a 32-bit word. The error type sits at bits [15:14] and an external-abort flag sits at bit [12]. Every other bit reads as zero. Software reads and writes the word through a coprocessor access port. Each access is checked against the current privilege level, the non-secure bit and the hypervisor's trap control. An access can be granted, refused as undefined, or redirected to the hypervisor as a trap.

Two event inputs copy the stored fields into another register. A "taken" event copies them into the fault status register of the guest kernel. A "deferred by barrier" event copies them into the deferred-interrupt status register instead. Both copies use the same bit positions, [15:14] and [12]. The unit does not hold either target register. It presents a write strobe for each target and a shared 32-bit data word, and the surrounding logic merges that word into the target.

All responses are registered. Read data, the undefined strobe, the trap strobe, the trap code and the target write strobes all appear in the cycle after the request or event is sampled.

Top module: `vserr_syndrome_reg`

## Requirements
- R1: While reset is asserted and after it is released, the stored fields are zero. Every output reads zero until the first access or event.
- R2: Only bits [15:14] (error type) and bit [12] (external flag) are stored. Read data bits [31:16], [13] and [11:0] are always zero, and writes to those bits are ignored. Writing 0xFFFFFFFF and reading back therefore gives 0x0000D000.
- R3: An access at privilege level 0 (priv = 0) raises the undefined strobe, returns zero read data and raises no trap.
- R4: An access at privilege level 1 traps when the hypervisor is enabled and its trap-control bit is set. The trap strobe rises with trap code 0x03 in either hypervisor state. The trap-state output is 1 when the hypervisor runs the 64-bit state (hyp_state32 = 0) and 0 otherwise. In every other case an access at level 1 is undefined.
- R5: At privilege level 2 a read returns the stored word and a write updates it. Neither strobe rises.
- R6: At privilege level 3 an access is undefined when the non-secure bit is 0. When the non-secure bit is 1 it behaves as at level 2.
- R7: An access that is undefined or trapped leaves the stored fields unchanged and returns zero read data. The undefined and trap strobes are never high together.
- R8: A taken event (with no deferred event) pulses the fault-status write strobe for one cycle. The target data word carries the stored fields at [15:14] and [12], with zeros elsewhere.
- R9: A deferred event pulses the deferred-status write strobe for one cycle with the same data word.
- R10: When both events arrive in the same cycle, only the deferred-status strobe rises. The data word holds the fields as stored before any write in that same cycle.
- R11: Every response appears exactly one clock cycle after its request or event is sampled. With no request or event, all strobes, the read data and the target data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Current privilege level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor is enabled |
| hyp_state32 | input | 1 | Hypervisor runs the 32-bit state |
| hyp_trap | input | 1 | Hypervisor trap-control bit for this register |
| nonsec | input | 1 | Non-secure state bit |
| acc_valid | input | 1 | Coprocessor access request |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when the access is not a granted read |
| undef_pulse | output | 1 | Access was undefined |
| trap_pulse | output | 1 | Access trapped to the hypervisor |
| trap_code | output | 6 | Trap code, 0x03 while trap_pulse is high, zero otherwise |
| trap_state64 | output | 1 | Trap is routed to a 64-bit hypervisor |
| ev_taken | input | 1 | Virtual error taken to level 1 in 32-bit state |
| ev_deferred | input | 1 | Virtual error deferred by a synchronization barrier |
| fsr_we | output | 1 | Write strobe for the fault status register |
| disr_we | output | 1 | Write strobe for the deferred-interrupt status register |
| syn_data | output | 32 | Syndrome fields at bits [15:14] and [12] for the selected target |

## Verification
The hardest situation to reach is an access and an event in the same cycle, where a granted write must not disturb the syndrome that the event copies out. It is hardest when both events fire together, because the deferred path must win on top of that. Random stimulus drives the events and the accesses independently each cycle. That makes these overlaps occur often. Directed vectors also force the case of a write together with both events. Trap redirection needs privilege level 1 with both the enable and the trap-control bits set. The random stimulus covers every combination of those flags together with both hypervisor states.

// File: rtl/vserr_syndrome_reg.sv
module vserr_syndrome_reg #(
  parameter logic [5:0] TRAP_EC = 6'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  priv,
  input  logic        hyp_en,
  input  logic        hyp_state32,
  input  logic        hyp_trap,
  input  logic        nonsec,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        undef_pulse,
  output logic        trap_pulse,
  output logic [5:0]  trap_code,
  output logic        trap_state64,
  input  logic        ev_taken,
  input  logic        ev_deferred,
  output logic        fsr_we,
  output logic        disr_we,
  output logic [31:0] syn_data
);

  logic [1:0] aet_q;
  logic       ext_q;

  wire        lvl_ok   = (priv == 2'd2) || (priv == 2'd3 && nonsec);
  wire        lvl_trap = (priv == 2'd1) && hyp_en && hyp_trap;
  wire        grant    = acc_valid && lvl_ok;
  wire        do_undef = acc_valid && !lvl_ok && !lvl_trap;
  wire        do_trap  = acc_valid && lvl_trap;
  wire [31:0] word     = {16'h0, aet_q, 1'b0, ext_q, 12'h0};
  wire        any_ev   = ev_taken || ev_deferred;
  wire [31:0] unused_wr = {wr_data[31:16], wr_data[13], wr_data[11:0], 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aet_q        <= 2'b00;
      ext_q        <= 1'b0;
      rd_data      <= 32'h0;
      undef_pulse  <= 1'b0;
      trap_pulse   <= 1'b0;
      trap_code    <= 6'h0;
      trap_state64 <= 1'b0;
      fsr_we       <= 1'b0;
      disr_we      <= 1'b0;
      syn_data     <= 32'h0;
    end else begin
      if (grant && acc_write) begin
        aet_q <= wr_data[15:14];
        ext_q <= wr_data[12];
      end
      rd_data      <= (grant && !acc_write) ? word : 32'h0;
      undef_pulse  <= do_undef;
      trap_pulse   <= do_trap;
      trap_code    <= do_trap ? TRAP_EC : 6'h0;
      trap_state64 <= do_trap && !hyp_state32;
      fsr_we       <= ev_taken && !ev_deferred;
      disr_we      <= ev_deferred;
      syn_data     <= any_ev ? word : 32'h0;
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFFFF2FFF) == 32'h0 && (syn_data & 32'hFFFF2FFF) == 32'h0);

  assert_level0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && priv == 2'd0) |=> (undef_pulse && !trap_pulse && rd_data == 32'h0));

  assert_trap_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (trap_code == TRAP_EC));

  assert_denied_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !grant) |=> $stable({aet_q, ext_q}));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_pulse && trap_pulse));

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fsr_we && disr_we));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !any_ev) |=> (!undef_pulse && !trap_pulse && !fsr_we && !disr_we && rd_data == 32'h0));

endmodule

// File: tb/test_vserr_syndrome_reg.sv
`timescale 1ns/1ps
module test_vserr_syndrome_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic        hyp_en = 1'b0, hyp_state32 = 1'b0, hyp_trap = 1'b0, nonsec = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] wr_data = 32'h0;
  logic        ev_taken = 1'b0, ev_deferred = 1'b0;
  logic [31:0] rd_data, syn_data;
  logic        undef_pulse, trap_pulse, trap_state64, fsr_we, disr_we;
  logic [5:0]  trap_code;

  int vectors = 0;
  int errors = 0;
  logic [1:0] m_aet = 2'b00;
  logic       m_ext = 1'b0;
  logic [31:0] e_rd, e_syn;
  logic        e_und, e_trp, e_t64, e_fwe, e_dwe;
  logic [5:0]  e_code;
  string       t_acc, t_ev;

  always #2.5 clk = ~clk;

  vserr_syndrome_reg i_vserr_syndrome_reg (
    .clk(clk), .rst_n(rst_n), .priv(priv), .hyp_en(hyp_en), .hyp_state32(hyp_state32),
    .hyp_trap(hyp_trap), .nonsec(nonsec), .acc_valid(acc_valid), .acc_write(acc_write),
    .wr_data(wr_data), .rd_data(rd_data), .undef_pulse(undef_pulse), .trap_pulse(trap_pulse),
    .trap_code(trap_code), .trap_state64(trap_state64), .ev_taken(ev_taken),
    .ev_deferred(ev_deferred), .fsr_we(fsr_we), .disr_we(disr_we), .syn_data(syn_data));

  function automatic logic [31:0] fields(input logic [1:0] a, input logic x);
    return {16'h0, a, 1'b0, x, 12'h0};
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] p, input logic he, input logic h32,
                       input logic ht, input logic ns, input logic v, input logic w,
                       input logic [31:0] d, input logic et, input logic ed);
    logic ok, trp;
    priv = p; hyp_en = he; hyp_state32 = h32; hyp_trap = ht; nonsec = ns;
    acc_valid = v; acc_write = w; wr_data = d; ev_taken = et; ev_deferred = ed;
    ok  = (p == 2'd2) || (p == 2'd3 && ns);
    trp = (p == 2'd1) && he && ht;
    e_rd   = (v && !w && ok) ? fields(m_aet, m_ext) : 32'h0;
    e_und  = v && !ok && !trp;
    e_trp  = v && trp;
    e_code = e_trp ? 6'h03 : 6'h00;
    e_t64  = e_trp && !h32;
    e_fwe  = et && !ed;
    e_dwe  = ed;
    e_syn  = (et || ed) ? fields(m_aet, m_ext) : 32'h0;
    if (v && w && ok) begin m_aet = d[15:14]; m_ext = d[12]; end
    if (tag != "") begin t_acc = tag; t_ev = tag; end
    else begin
      case (p) 2'd0: t_acc = "R3"; 2'd1: t_acc = "R4"; 2'd2: t_acc = "R5"; default: t_acc = "R6"; endcase
      if (!v) t_acc = "R11";
      t_ev = (et && ed) ? "R10" : ed ? "R9" : et ? "R8" : "R11";
    end
    @(negedge clk);
    check(t_acc, "access", {rd_data, undef_pulse, trap_pulse, trap_code, trap_state64},
          {e_rd, e_und, e_trp, e_code, e_t64});
    check(t_ev, "event", {fsr_we, disr_we, syn_data}, {e_fwe, e_dwe, e_syn});
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check("R1", "reset outputs", {rd_data, undef_pulse, trap_pulse, trap_code, trap_state64, fsr_we, disr_we, syn_data},
          72'h0);
    rst_n = 1'b1;
    // R1: stored fields zero after reset
    apply("R1", 2'd2, 0, 0, 0, 0, 1, 0, 32'h0, 0, 0);
    // R2: reserved bits ignored on write
    apply("R2", 2'd2, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 0, 0);
    apply("R2", 2'd2, 0, 0, 0, 0, 1, 0, 32'h0, 0, 0);
    check("R2", "readback", rd_data, 32'h0000_D000);
    // R7: denied writes at each refusing level leave the value
    apply("R7", 2'd0, 1, 0, 1, 1, 1, 1, 32'h0, 0, 0);
    apply("R7", 2'd1, 1, 1, 1, 0, 1, 1, 32'h0, 0, 0);
    apply("R7", 2'd1, 1, 0, 0, 1, 1, 1, 32'h0, 0, 0);
    apply("R7", 2'd3, 1, 0, 1, 0, 1, 1, 32'h0, 0, 0);
    apply("R7", 2'd3, 0, 0, 0, 1, 1, 0, 32'h0, 0, 0);
    check("R7", "value kept", rd_data, 32'h0000_D000);
    // R4: trap in both hypervisor states
    apply("R4", 2'd1, 1, 0, 1, 0, 1, 0, 32'h0, 0, 0);
    apply("R4", 2'd1, 1, 1, 1, 0, 1, 0, 32'h0, 0, 0);
    // R10: write with both events, pre-write fields copied to deferred target
    apply("R10", 2'd2, 0, 0, 0, 0, 1, 1, 32'h0000_4000, 1, 1);
    apply("R8", 2'd0, 0, 0, 0, 0, 0, 0, 32'h0, 1, 0);
    check("R8", "taken data", syn_data, 32'h0000_4000);
    apply("R9", 2'd0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 1);
    // R11: idle cycle quiet
    apply("R11", 2'd2, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply("", r[1:0], r[2], r[3], r[4], r[5], r[6] | r[7], r[8], $urandom, r[9] & r[10], r[11] & r[12]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule